// File: doc/BRIEF.md
# Least-Recently-Served Bus Arbiter

This block arbitrates a shared parallel bus among five masters when the chip acts as the bus host. The five masters are the local controller, which raises an internal active-high request, and four external devices, which use active-low request and grant pins. Priority is a ranked list. When a transfer ends, the master that ran it drops to the bottom of the list, and the other four keep their order relative to each other. This is not a rotating pointer. Only the master that was served moves.

A single bus-idle input gives the transfer timing. The bus goes busy when that input falls, and the master holding the grant at that moment is recorded as the owner of the transfer. When the input rises again, the transfer is complete and the list is updated. While the bus is idle, the grant follows the best active request on every clock. While the bus is busy, the grant stays with its holder until that holder withdraws its request. If nobody requests the bus, the grant is parked on the local controller.

When host mode is off, the block issues no grants. It forwards the local controller's request, as an active-low pin, to an external arbiter.

Top module: `lruPciArbiter`

## Requirements
- R1: During and right after reset, no grant is active (`devGntN` = 4'b1111, `localGnt` = 0). The priority list starts as controller, device 1, device 2, device 3, device 4. Master index 0 is the controller, and index k is the device on `devReqN[k-1]` / `devGntN[k-1]`.
- R2: In host mode, while `busIdle` is 1, the grant one clock later goes to the requesting master that stands highest in the current list.
- R3: At most one grant (among `localGnt` and the low bits of `devGntN`) is active in any cycle.
- R4: The owner of a transfer is the master granted in the cycle where `busIdle` is first seen low. On the clock where `busIdle` is seen high again, the owner moves to the bottom of the list and the others keep their relative order. The new list already applies to the grant chosen on that same clock.
- R5: From reset, transfers by device 1, then the controller, then device 3 leave the list as device 2, device 4, device 1, controller, device 3.
- R6: In host mode with no active request, the grant one clock later is `localGnt`. The bus is parked on the controller.
- R7: While `busIdle` is 0, the grant holder keeps the grant as long as it keeps requesting. If it withdraws, the grant moves one clock later to the best remaining request.
- R8: A device whose request pin stays high is never granted, so fewer than four attached devices need no change.
- R9: With `hostMode` = 0, the grants are inactive one clock later, the list does not change, and `extReqN` is the inverse of `localReq` in the same cycle. With `hostMode` = 1, `extReqN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostMode | input | 1 | 1 enables arbitration; 0 hands arbitration to an external arbiter |
| busIdle | input | 1 | 1 while no transfer is in progress; its rising edge ends a transfer |
| localReq | input | 1 | Local controller bus request, active high |
| devReqN | input | NUM_DEV | External device requests, active low |
| localGnt | output | 1 | Grant to the local controller, active high |
| devGntN | output | NUM_DEV | Grants to the external devices, active low |
| extReqN | output | 1 | Local request forwarded to an external arbiter, active low |

## Verification
All grants come from registers. A grant is due exactly one clock after the inputs it depends on are sampled. A list change caused by a rising `busIdle` already affects the grant chosen on that same edge. Only `extReqN` is combinational and can be checked in the same cycle. The reference model advances on each rising edge from the inputs held since the previous falling edge. The outputs are compared 5 ns after that edge, and directed checks sample at the following falling edge, so every grant is read one register stage after its cause. This covers the device 1, controller, device 3 sequence and the hold-while-busy case.

// File: rtl/lruArbPkg.sv
package lruArbPkg;

  typedef struct packed {
    logic arbOn;
    logic idleWin;
    logic xferStart;
    logic xferEnd;
  } ctlStrobes_t;

endpackage

// File: rtl/lruArbCtrl.sv
module lruArbCtrl
  import lruArbPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostMode,
  input  logic        busIdle,
  output ctlStrobes_t strobes
);

  logic idlePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idlePrev <= 1'b1;
    else       idlePrev <= busIdle;
  end

  always_comb begin
    strobes.arbOn     = hostMode;
    strobes.idleWin   = busIdle;
    strobes.xferStart = idlePrev && !busIdle;
    strobes.xferEnd   = hostMode && busIdle && !idlePrev;
  end

endmodule

// File: rtl/lruArbDatapath.sv
module lruArbDatapath
  import lruArbPkg::*;
#(
  parameter int NUM_MASTERS = 5,
  localparam int IDX_W = $clog2(NUM_MASTERS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobes_t            strobes,
  input  logic [NUM_MASTERS-1:0] reqVec,
  output logic                   gntValid,
  output logic [IDX_W-1:0]       gntIdx
);

  logic [IDX_W-1:0] orderQ    [NUM_MASTERS];
  logic [IDX_W-1:0] orderNext [NUM_MASTERS];
  logic [IDX_W-1:0] shiftVal  [NUM_MASTERS];
  logic [IDX_W-1:0] ownerQ;
  logic [IDX_W-1:0] ownerPos;
  logic [IDX_W-1:0] winIdx;
  logic             winFound;
  logic             regrant;

  always_comb begin
    ownerPos = '0;
    for (int i = 0; i < NUM_MASTERS; i++) begin
      if (orderQ[i] == ownerQ) ownerPos = IDX_W'(i);
    end
  end

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_ord
    if (i == NUM_MASTERS - 1) begin : g_last
      assign shiftVal[i] = ownerQ;
    end else begin : g_mid
      assign shiftVal[i] = orderQ[i+1];
    end
    assign orderNext[i] = (strobes.xferEnd && (IDX_W'(i) >= ownerPos))
                          ? shiftVal[i] : orderQ[i];
  end

  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    for (int i = NUM_MASTERS - 1; i >= 0; i--) begin
      if (reqVec[orderNext[i]]) begin
        winFound = 1'b1;
        winIdx   = orderNext[i];
      end
    end
  end

  assign regrant = !gntValid || strobes.idleWin || !reqVec[gntIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MASTERS; i++) orderQ[i] <= IDX_W'(i);
      ownerQ   <= '0;
      gntValid <= 1'b0;
      gntIdx   <= '0;
    end else begin
      if (strobes.arbOn) begin
        for (int i = 0; i < NUM_MASTERS; i++) orderQ[i] <= orderNext[i];
      end
      if (strobes.xferStart) ownerQ <= gntIdx;
      if (!strobes.arbOn) begin
        gntValid <= 1'b0;
        gntIdx   <= '0;
      end else if (regrant) begin
        gntValid <= 1'b1;
        gntIdx   <= winFound ? winIdx : '0;
      end
    end
  end

endmodule

// File: rtl/lruPciArbiter.sv
module lruPciArbiter
  import lruArbPkg::*;
#(
  parameter int NUM_DEV = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostMode,
  input  logic               busIdle,
  input  logic               localReq,
  input  logic [NUM_DEV-1:0] devReqN,
  output logic               localGnt,
  output logic [NUM_DEV-1:0] devGntN,
  output logic               extReqN
);

  localparam int NUM_MASTERS = NUM_DEV + 1;
  localparam int IDX_W = $clog2(NUM_MASTERS);

  ctlStrobes_t            strobes;
  logic [NUM_MASTERS-1:0] reqVec;
  logic                   gntValid;
  logic [IDX_W-1:0]       gntIdx;

  assign reqVec = {~devReqN, localReq};

  lruArbCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostMode (hostMode),
    .busIdle  (busIdle),
    .strobes  (strobes)
  );

  lruArbDatapath #(.NUM_MASTERS(NUM_MASTERS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .reqVec   (reqVec),
    .gntValid (gntValid),
    .gntIdx   (gntIdx)
  );

  assign localGnt = gntValid && (gntIdx == '0);

  for (genvar k = 0; k < NUM_DEV; k++) begin : g_gnt
    assign devGntN[k] = !(gntValid && (gntIdx == IDX_W'(k + 1)));
  end

  assign extReqN = hostMode ? 1'b1 : !localReq;

endmodule

// File: rtl/lruPciArbiter_chk.sv
module lruPciArbiter_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostMode,
  input logic               busIdle,
  input logic               localReq,
  input logic [NUM_DEV-1:0] devReqN,
  input logic               localGnt,
  input logic [NUM_DEV-1:0] devGntN,
  input logic               extReqN
);

  logic [NUM_DEV:0] gntVec;
  logic [NUM_DEV:0] reqVec;

  assign gntVec = {~devGntN, localGnt};
  assign reqVec = {~devReqN, localReq};

  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(gntVec));

  p_nonhost_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !hostMode |=> (gntVec == '0));

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostMode && !busIdle && (|(gntVec & reqVec))) |=> (gntVec == $past(gntVec)));

  p_park_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hostMode && (reqVec == '0)) |=> localGnt);

  p_req_before_grant_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostMode |=> ((~devGntN & $past(devReqN)) == '0));

endmodule

bind lruPciArbiter lruPciArbiter_chk #(.NUM_DEV(NUM_DEV)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .hostMode (hostMode),
  .busIdle  (busIdle),
  .localReq (localReq),
  .devReqN  (devReqN),
  .localGnt (localGnt),
  .devGntN  (devGntN),
  .extReqN  (extReqN)
);

// File: tb/lruPciArbiter_test.sv
`timescale 1ns/1ps
module lruPciArbiter_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostMode = 1'b0;
  logic       busIdle = 1'b1;
  logic       localReq = 1'b0;
  logic [3:0] devReqN = 4'hF;
  logic       localGnt;
  logic [3:0] devGntN;
  logic       extReqN;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lruPciArbiter uut (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .busIdle(busIdle),
    .localReq(localReq), .devReqN(devReqN), .localGnt(localGnt),
    .devGntN(devGntN), .extReqN(extReqN)
  );

  // behavioural reference model
  int  mOrder[$];
  int  mGnt = 0;
  bit  mValid = 1'b0;
  int  mOwner = 0;
  bit  mIdlePrev = 1'b1;

  function automatic bit reqOf(int m);
    return (m == 0) ? localReq : !devReqN[m-1];
  endfunction

  function automatic int gntCode();
    int c = -1;
    int n = 0;
    if (localGnt) begin c = 0; n++; end
    for (int k = 0; k < 4; k++) if (!devGntN[k]) begin c = k + 1; n++; end
    return (n > 1) ? 9 : c;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mOrder = '{0, 1, 2, 3, 4};
      mGnt = 0; mValid = 1'b0; mOwner = 0; mIdlePrev = 1'b1;
    end else begin
      if (hostMode && busIdle && !mIdlePrev) begin
        foreach (mOrder[i]) if (mOrder[i] == mOwner) begin
          mOrder.delete(i);
          break;
        end
        mOrder.push_back(mOwner);
      end
      if (mIdlePrev && !busIdle) mOwner = mGnt;
      if (!hostMode) begin
        mValid = 1'b0; mGnt = 0;
      end else if (!mValid || busIdle || !reqOf(mGnt)) begin
        mValid = 1'b1; mGnt = 0;
        foreach (mOrder[i]) if (reqOf(mOrder[i])) begin
          mGnt = mOrder[i];
          break;
        end
      end
      mIdlePrev = busIdle;
    end
  end

  always @(posedge clk) begin
    #5;
    if (rstN && !finished) begin
      check("R2/R4 model grant", gntCode(), mValid ? mGnt : -1);
      check("R9 model extReqN", int'(extReqN), hostMode ? 1 : int'(!localReq));
    end
  end

  task automatic setReq(int m, bit on);
    if (m == 0) localReq = on;
    else devReqN[m-1] = !on;
  endtask

  task automatic xfer(int m);
    @(negedge clk); setReq(m, 1'b1);
    @(negedge clk); check("R2 xfer grant", gntCode(), m);
    busIdle = 1'b0;
    repeat (3) @(negedge clk);
    busIdle = 1'b1; setReq(m, 1'b0);
    @(negedge clk);
  endtask

  task automatic allReq();
    localReq = 1'b1; devReqN = 4'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset grants", gntCode(), -1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 no grant after reset, non-host", gntCode(), -1);
    hostMode = 1'b1;
    @(negedge clk);
    check("R6 park on controller", gntCode(), 0);

    // R5 sequence: device 1, controller, device 3
    xfer(1); xfer(0); xfer(3);
    check("R6 park after transfers", gntCode(), 0);
    allReq();
    @(negedge clk); check("R5 top is device 2", gntCode(), 2);
    devReqN[1] = 1'b1;
    @(negedge clk); check("R5 next is device 4", gntCode(), 4);
    devReqN[3] = 1'b1;
    @(negedge clk); check("R5 next is device 1", gntCode(), 1);
    devReqN[0] = 1'b1;
    @(negedge clk); check("R5 next is controller", gntCode(), 0);
    localReq = 1'b0;
    @(negedge clk); check("R5 last is device 3", gntCode(), 3);
    devReqN = 4'hF;

    // R4: device 4 moves back: list 2,1,0,3,4
    xfer(4);
    allReq();
    @(negedge clk); check("R4 top after move", gntCode(), 2);
    devReqN[1] = 1'b1;
    @(negedge clk); check("R4 second after move", gntCode(), 1);
    localReq = 1'b0; devReqN = 4'hF;

    // R7 hold while busy
    @(negedge clk); devReqN[3] = 1'b0;
    @(negedge clk); check("R7 device 4 granted", gntCode(), 4);
    busIdle = 1'b0;
    @(negedge clk); allReq();
    repeat (2) @(negedge clk);
    check("R7 held while busy", gntCode(), 4);
    devReqN[3] = 1'b1;
    @(negedge clk); check("R7 moves on withdraw", gntCode(), 2);
    busIdle = 1'b1; localReq = 1'b0; devReqN = 4'hF;
    @(negedge clk);

    // R9 non-host
    hostMode = 1'b0; localReq = 1'b1; devReqN = 4'h0;
    #1 check("R9 extReqN forwards request", int'(extReqN), 0);
    @(negedge clk); check("R9 no grant in non-host", gntCode(), -1);
    busIdle = 1'b0;
    @(negedge clk); busIdle = 1'b1;
    @(negedge clk); check("R9 still no grant", gntCode(), -1);
    hostMode = 1'b1;
    #1 check("R9 extReqN high in host", int'(extReqN), 1);
    @(negedge clk); check("R9 list unchanged in non-host", gntCode(), 2);
    localReq = 1'b0; devReqN = 4'hF;
    @(negedge clk);

    // R8: device 4 absent, random traffic
    begin
      int dev4Grants = 0;
      for (int n = 0; n < 600; n++) begin
        @(negedge clk);
        if (gntCode() == 4) dev4Grants++;
        localReq = 1'($urandom_range(0, 1));
        devReqN = {1'b1, 3'($urandom_range(0, 7))};
        busIdle = ($urandom_range(0, 3) != 0);
        hostMode = ($urandom_range(0, 15) != 0);
      end
      @(negedge clk);
      if (gntCode() == 4) dev4Grants++;
      check("R8 unused device never granted", dev4Grants, 0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule